// File: doc/BRIEF.md
# Video Scale and Region Controller

This block sits in front of a line FIFO in a video scaler. It follows the position of the incoming stream within a field and decides, for every input pixel, whether it is written into the FIFO. Horizontally it keeps `x_keep` of every `x_span` pixels inside a window that starts `x_ofs` valid pixels into each line. Vertically it keeps `y_keep` of every `y_span` lines inside a window that starts at line `y_ofs`. The kept pixels follow an even spread produced by an error accumulator.

A separate vertical bypass region starts at line `byp_start` and covers `byp_cnt` lines. Inside it no scaling happens and every active pixel is kept. The output format code is also forced to 8-bit greyscale, whatever the configured format, so the region can carry data such as teletext into memory unchanged. When the bypass region and the scaling window overlap, bypass wins.

The keep strobe is combinational in the pixel's own cycle and acts as the FIFO write enable. Per-line state changes only at a falling edge of the horizontal reference and at vertical sync, so it stays constant for the whole of a line.

Top module: `vscale_region_ctrl`

## Requirements
- R1: When `x_keep` < `x_span`, window pixel k (k = 0 for the first pixel of the window) is kept exactly when floor((k+1)·x_keep/x_span) differs from floor(k·x_keep/x_span).
- R2: Pixel position counts the cycles with `pix_vld`=1 and `href`=1, starting at 0 for the first such cycle of a line. The horizontal window covers positions `x_ofs` to `x_ofs+x_span-1`, and positions outside it are never kept on a scaled line.
- R3: When `x_keep` >= `x_span`, every pixel inside the horizontal window is kept on a kept line.
- R4: When `y_keep` < `y_span`, `line_keep` is 1 on the j-th scaled window line (j counts window lines outside bypass since vsync, from 0) exactly when floor((j+1)·y_keep/y_span) differs from floor(j·y_keep/y_span). It is 1 on every window line when `y_keep` >= `y_span`, and 0 outside the window and bypass. On a scaled line `pix_keep` is 1 only if `line_keep` is 1.
- R5: `vsync`=1 at a clock edge makes the line index 0 and restarts the vertical pattern. Each falling edge of `href` advances the line index by one.
- R6: On a line with index in `byp_start` to `byp_start+byp_cnt-1`, `byp_act` and `line_keep` are 1, and `pix_keep` equals `pix_vld` AND `href`.
- R7: `fmt_out` is 2'b11 (8-bit greyscale) while `byp_act` is 1, and equals `fmt_sel` otherwise.
- R8: Bypass takes priority over the scaling window, and bypass lines do not advance the vertical keep pattern.
- R9: `pix_keep` is 1 only when `pix_vld` and `href` are both 1. After reset the line index, pixel position and both accumulators are 0.
- R10: A rising edge of `href` restarts the pixel position and the horizontal pattern in that same cycle.
- R11: `byp_cnt`=0 disables the bypass region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Input pixel present this cycle |
| href | input | 1 | Horizontal reference, high over the active line |
| vsync | input | 1 | Vertical sync, restarts the line count |
| x_ofs | input | PW | Horizontal window start, in valid pixels |
| x_span | input | PW | Input pixels per horizontal group (window length) |
| x_keep | input | PW | Pixels kept per horizontal group |
| y_ofs | input | LW | First line of the scaling window |
| y_span | input | LW | Lines per vertical group (window height) |
| y_keep | input | LW | Lines kept per vertical group |
| byp_start | input | LW | First line of the bypass region |
| byp_cnt | input | LW | Number of bypass lines |
| fmt_sel | input | 2 | Configured output format code |
| pix_keep | output | 1 | FIFO write enable for the current pixel |
| line_keep | output | 1 | Current line is kept |
| byp_act | output | 1 | Current line lies in the bypass region |
| fmt_out | output | 2 | Effective format code, 2'b11 = greyscale |

## Verification
The horizontal keep decision and the vertical region decision meet in the same pixel cycle. This matters most on the line where the bypass region begins inside the scaling window, and at the `href` rising edge, where the pixel pattern restarts while the line state must already belong to the new line. The bench provokes this with a frame whose bypass lines lie in the middle of the scaling window, and with lines whose first active cycle carries a valid pixel. Every cycle a behavioural model predicts the keep strobe, line flag, bypass flag and format from line and pixel counts and the floor formula. The bench then compares all four outputs, and in particular confirms that the vertical pattern resumes unshifted after the bypass lines.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam logic [1:0] FMT_GREY = 2'b11;
endpackage

// File: rtl/vsr_span_hit.sv
module vsr_span_hit #(
  parameter int W = 12
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] len,
  output logic         hit
);
  logic [W:0] rel;
  always_comb begin
    rel = {1'b0, pos} - {1'b0, start};
    hit = (pos >= start) && (rel < {1'b0, len});
  end
endmodule

// File: rtl/vsr_ratio_step.sv
module vsr_ratio_step #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         take,
  output logic [W-1:0] acc_nxt
);
  logic [W:0] sum;
  logic       keep_all;
  logic       over;
  always_comb begin
    sum      = {1'b0, acc} + {1'b0, num};
    keep_all = (num >= den);
    over     = (sum >= {1'b0, den});
    take     = keep_all | over;
    if (keep_all)  acc_nxt = '0;
    else if (over) acc_nxt = W'(sum - {1'b0, den});
    else           acc_nxt = sum[W-1:0];
  end
endmodule

// File: rtl/vsr_pixel_track.sv
module vsr_pixel_track #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          href,
  input  logic          href_rise,
  input  logic          pix_vld,
  input  logic [PW-1:0] x_ofs,
  input  logic [PW-1:0] x_span,
  input  logic [PW-1:0] x_keep,
  output logic          h_take
);
  localparam logic [PW-1:0] POS_MAX = {PW{1'b1}};

  logic [PW-1:0] pos_q, pos_d, pos_cur;
  logic [PW-1:0] acc_q, acc_d, acc_cur, acc_step;
  logic          in_win, step_take, pix_en;

  vsr_span_hit #(.W(PW)) u_win (
    .pos(pos_cur), .start(x_ofs), .len(x_span), .hit(in_win)
  );

  vsr_ratio_step #(.W(PW)) u_step (
    .acc(acc_cur), .num(x_keep), .den(x_span),
    .take(step_take), .acc_nxt(acc_step)
  );

  always_comb begin
    pos_cur = href_rise ? '0 : pos_q;
    acc_cur = href_rise ? '0 : acc_q;
    pix_en  = pix_vld & href;
    h_take  = in_win & step_take;
    pos_d   = pos_cur;
    acc_d   = acc_cur;
    if (pix_en) begin
      if (pos_cur != POS_MAX) pos_d = pos_cur + 1'b1;
      if (in_win)             acc_d = acc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      acc_q <= '0;
    end else begin
      pos_q <= pos_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/vsr_line_track.sv
module vsr_line_track #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic          href_fall,
  input  logic [LW-1:0] y_ofs,
  input  logic [LW-1:0] y_span,
  input  logic [LW-1:0] y_keep,
  input  logic [LW-1:0] byp_start,
  input  logic [LW-1:0] byp_cnt,
  output logic          v_take,
  output logic          in_byp
);
  localparam logic [LW-1:0] LINE_MAX = {LW{1'b1}};

  logic [LW-1:0] line_q, line_d;
  logic [LW-1:0] acc_q, acc_d, acc_step;
  logic          in_win, step_take, scaled;

  vsr_span_hit #(.W(LW)) u_win (
    .pos(line_q), .start(y_ofs), .len(y_span), .hit(in_win)
  );

  vsr_span_hit #(.W(LW)) u_byp (
    .pos(line_q), .start(byp_start), .len(byp_cnt), .hit(in_byp)
  );

  vsr_ratio_step #(.W(LW)) u_step (
    .acc(acc_q), .num(y_keep), .den(y_span),
    .take(step_take), .acc_nxt(acc_step)
  );

  always_comb begin
    scaled = in_win & ~in_byp;
    v_take = in_byp | (in_win & step_take);
    line_d = line_q;
    acc_d  = acc_q;
    if (vsync) begin
      line_d = '0;
      acc_d  = '0;
    end else if (href_fall) begin
      if (line_q != LINE_MAX) line_d = line_q + 1'b1;
      if (scaled)             acc_d  = acc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      acc_q  <= '0;
    end else begin
      line_q <= line_d;
      acc_q  <= acc_d;
    end
  end
endmodule

// File: rtl/vscale_region_ctrl.sv
module vscale_region_ctrl
  import vsr_pkg::*;
#(
  parameter int PW = 12,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_vld,
  input  logic          href,
  input  logic          vsync,
  input  logic [PW-1:0] x_ofs,
  input  logic [PW-1:0] x_span,
  input  logic [PW-1:0] x_keep,
  input  logic [LW-1:0] y_ofs,
  input  logic [LW-1:0] y_span,
  input  logic [LW-1:0] y_keep,
  input  logic [LW-1:0] byp_start,
  input  logic [LW-1:0] byp_cnt,
  input  logic [1:0]    fmt_sel,
  output logic          pix_keep,
  output logic          line_keep,
  output logic          byp_act,
  output logic [1:0]    fmt_out
);
  logic href_q;
  logic href_rise, href_fall;
  logic h_take, v_take, in_byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) href_q <= 1'b0;
    else        href_q <= href;
  end

  always_comb begin
    href_rise = href & ~href_q;
    href_fall = href_q & ~href;
  end

  vsr_pixel_track #(.PW(PW)) u_pix (
    .clk(clk), .rst_n(rst_n), .href(href), .href_rise(href_rise),
    .pix_vld(pix_vld), .x_ofs(x_ofs), .x_span(x_span), .x_keep(x_keep),
    .h_take(h_take)
  );

  vsr_line_track #(.LW(LW)) u_line (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .href_fall(href_fall),
    .y_ofs(y_ofs), .y_span(y_span), .y_keep(y_keep),
    .byp_start(byp_start), .byp_cnt(byp_cnt),
    .v_take(v_take), .in_byp(in_byp)
  );

  always_comb begin
    byp_act   = in_byp;
    line_keep = v_take;
    pix_keep  = pix_vld & href & (in_byp | (v_take & h_take));
    fmt_out   = in_byp ? FMT_GREY : fmt_sel;
  end
endmodule

// File: rtl/vsr_chk.sv
module vsr_chk
  import vsr_pkg::*;
#(
  parameter int PW = 12,
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_vld,
  input logic          href,
  input logic          vsync,
  input logic [PW-1:0] x_ofs,
  input logic [PW-1:0] x_span,
  input logic [PW-1:0] x_keep,
  input logic [LW-1:0] y_ofs,
  input logic [LW-1:0] y_span,
  input logic [LW-1:0] y_keep,
  input logic [LW-1:0] byp_start,
  input logic [LW-1:0] byp_cnt,
  input logic [1:0]    fmt_sel,
  input logic          pix_keep,
  input logic          line_keep,
  input logic          byp_act,
  input logic [1:0]    fmt_out
);
  p_keep_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_keep |-> (pix_vld && href));

  p_byp_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_act && pix_vld && href) |-> (pix_keep && line_keep));

  p_byp_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byp_act |-> (fmt_out == FMT_GREY));

  p_fmt_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_act |-> (fmt_out == fmt_sel));

  p_line_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_keep && !byp_act) |-> line_keep);

  p_byp_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_cnt == '0) |-> !byp_act);

  p_line_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (href && $past(href) && !$past(vsync) && $stable(byp_start) && $stable(byp_cnt))
      |-> $stable(byp_act));
endmodule

bind vscale_region_ctrl vsr_chk #(.PW(PW), .LW(LW)) u_chk (.*);

// File: tb/tb_vscale_region_ctrl.sv
module tb_vscale_region_ctrl;
  localparam int PW = 12;
  localparam int LW = 10;

  logic clk, rst_n, pix_vld, href, vsync;
  logic [PW-1:0] x_ofs, x_span, x_keep;
  logic [LW-1:0] y_ofs, y_span, y_keep, byp_start, byp_cnt;
  logic [1:0] fmt_sel;
  logic pix_keep, line_keep, byp_act;
  logic [1:0] fmt_out;

  vscale_region_ctrl #(.PW(PW), .LW(LW)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  string ptag = "R1";

  int m_line, m_j, m_px;
  bit m_hprev;

  function automatic bit keep_at(int k, int num, int den);
    if (num >= den) return 1'b1;
    return ((k + 1) * num) / den != (k * num) / den;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit h, bit vs);
    bit rise, fall, byp, vwin, hwin, lk, hk, pk;
    int pc, k;
    pix_vld = v; href = h; vsync = vs;
    @(negedge clk);
    rise = h && !m_hprev;
    fall = m_hprev && !h;
    pc   = rise ? 0 : m_px;                       // R10
    byp  = (byp_cnt != 0) && m_line >= byp_start && m_line < byp_start + byp_cnt;
    vwin = m_line >= y_ofs && m_line < y_ofs + y_span;
    lk   = byp || (vwin && keep_at(m_j, y_keep, y_span));
    k    = pc - x_ofs;
    hwin = pc >= x_ofs && pc < x_ofs + x_span;     // R2
    hk   = hwin && keep_at(k, x_keep, x_span);
    pk   = v && h && (byp || (lk && hk));
    chk(ptag, pix_keep, pk);
    chk("R4", line_keep, lk);
    chk("R6", byp_act, byp);
    chk("R7", fmt_out, byp ? 3 : fmt_sel);
    @(posedge clk);
    if (vs) begin m_line = 0; m_j = 0; end       // R5
    else if (fall) begin
      if (vwin && !byp) m_j++;                    // R8
      m_line++;
    end
    m_px    = pc + ((v && h) ? 1 : 0);
    m_hprev = h;
    #1;
  endtask

  task automatic do_line(int len, int pat);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < len; i++) begin
      bit v;
      case (pat)
        0: v = 1'b1;
        1: v = (i % 2) == 0;
        default: v = ((i * 7) % 3) != 0;
      endcase
      cyc(v, 1'b1, 1'b0);
    end
  endtask

  task automatic do_frame(int nlines, int len);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    for (int l = 0; l < nlines; l++) do_line(len, l % 3);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_vld = 1'b0; href = 1'b0; vsync = 1'b0;
    x_ofs = 2; x_span = 10; x_keep = 4;
    y_ofs = 1; y_span = 5; y_keep = 3;
    byp_start = 7; byp_cnt = 2; fmt_sel = 2'b01;
    m_line = 0; m_j = 0; m_px = 0; m_hprev = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state, line 0 outside window and bypass
    ptag = "R9";
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    // R1 R2 R10: fractional horizontal and vertical ratios, bypass after window
    ptag = "R1";
    do_frame(11, 18);
    // R3: horizontal ratio at or above one
    ptag = "R3";
    x_ofs = 0; x_span = 6; x_keep = 9; y_keep = 5; fmt_sel = 2'b10;
    do_frame(8, 12);
    // R8: bypass lines inside the scaling window
    ptag = "R8";
    x_ofs = 3; x_span = 7; x_keep = 3;
    y_ofs = 0; y_span = 9; y_keep = 4; byp_start = 3; byp_cnt = 2;
    do_frame(11, 14);
    // R11: bypass disabled; R5 vsync mid-frame restart
    ptag = "R11";
    byp_start = 0; byp_cnt = 0; y_ofs = 2; y_span = 6; y_keep = 1;
    x_ofs = 1; x_span = 5; x_keep = 2; fmt_sel = 2'b00;
    do_frame(4, 10);
    ptag = "R5";
    do_frame(9, 10);
    // R6 R7: bypass from line 0
    ptag = "R6";
    byp_start = 0; byp_cnt = 3;
    do_frame(5, 9);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule